// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two W-bit buses, called A and B, and can carry a word in either direction. Each direction has a capture register with its own rising-edge clock. The A-side register samples the A bus and the B-side register samples the B bus. A select input for each direction chooses what that direction drives onto the far bus: either the live word on the near bus or the held word in its register. The registers load on every rising edge of their clocks, whatever the selects and enables are set to. The block can therefore take a snapshot of a bus while it is isolated from that bus.

The bus pins are not modelled as inout. Each bus has its own input vector, output vector and per-bit output-enable vector, so the parent or the pad ring does the tri-state resolution. The B side drives when `oe_ab` is high. The A side drives when `oe_ba_n` is low. The two enables are decoded into one of four named drive modes:

- `MODE_ISOLATE` (`oe_ab`=0, `oe_ba_n`=1): neither bus is driven.
- `MODE_TO_B` (1,1): only B is driven.
- `MODE_TO_A` (0,0): only A is driven.
- `MODE_BOTH` (1,0): both buses are driven.

The mode follows the enables combinationally. Any mode can move to any other in the same cycle; there are no sequenced transitions. When both buses are driven with live data and no other source is on either bus, the two paths form a loop that keeps each bus at its last value.

Top module: `dual_bus_xcvr`

## Requirements
- R1: When `rst` is high at a rising edge of `clk_ab` or `clk_ba`, the register on that clock is cleared to zero. Afterwards a stored-select path outputs 8'h00.
- R2: At every rising edge of `clk_ab`, the A-side register loads `a_in`, whatever the values of `sel_ab`, `sel_ba`, `oe_ab` and `oe_ba_n`.
- R3: At every rising edge of `clk_ba`, the B-side register loads `b_in`, whatever the values of the selects and enables.
- R4: `b_oe` is all ones when `oe_ab`=1 and all zeros when `oe_ab`=0. `a_oe` is all ones when `oe_ba_n`=0 and all zeros when `oe_ba_n`=1.
- R5: When `sel_ab`=0, `b_out` equals `a_in` in the same cycle. When `sel_ab`=1, `b_out` equals the A-side register.
- R6: When `sel_ba`=0, `a_out` equals `b_in` in the same cycle. When `sel_ba`=1, `a_out` equals the B-side register.
- R7: In isolation (`oe_ab`=0, `oe_ba_n`=1), neither bus is driven and both registers still capture on their clocks.
- R8: With `oe_ab`=1, `oe_ba_n`=1 and `sel_ab`=0, the B bus carries the A word. Pulsing both clocks then loads that word into both registers.
- R9: With `oe_ab`=0, `oe_ba_n`=0 and `sel_ba`=0, the A bus carries the B word. Pulsing both clocks then loads that word into both registers.
- R10: With `oe_ab`=1, `oe_ba_n`=0 and both selects 1, the B bus carries the A-side register and the A bus carries the B-side register at the same time.
- R11: With both buses driven live (`oe_ab`=1, `oe_ba_n`=0, both selects 0) and no external driver on either bus, each bus keeps the value it had when the external driver was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-side register (rising edge) |
| clk_ba | input | 1 | Capture clock of the B-side register (rising edge) |
| rst | input | 1 | Synchronous active-high clear, sampled on each capture clock |
| oe_ab | input | 1 | B-side drive enable, active high |
| oe_ba_n | input | 1 | A-side drive enable, active low |
| sel_ab | input | 1 | B output source: 0 live A, 1 stored A |
| sel_ba | input | 1 | A output source: 0 live B, 1 stored B |
| a_in | input | W | Value seen on the A bus |
| a_out | output | W | Value offered to the A bus |
| a_oe | output | W | Per-bit drive enable for the A bus |
| b_in | input | W | Value seen on the B bus |
| b_out | output | W | Value offered to the B bus |
| b_oe | output | W | Per-bit drive enable for the B bus |

## Verification
Some behaviours are checked by assertions on every edge of the capture clocks:

- each enable vector follows its own enable polarity, and isolation drives nothing;
- each stored path presents the word its bus held one capture edge earlier;
- each live path is transparent;
- the first edge after reset shows a cleared register.

Other behaviours depend on how the external bus resolves, so only the bench scenarios can show them. The bench models the bus with a registered keeper and external drivers. These scenarios cover copying one bus into both registers through the driven opposite bus, the keeper loop holding a value after the external driver is released, and the absence of contention throughout the run.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Drive state of the two bus sides, decoded from the enables
    typedef enum logic [1:0] {
        MODE_ISOLATE   = 2'd0,
        MODE_TO_B      = 2'd1,
        MODE_TO_A      = 2'd2,
        MODE_BOTH      = 2'd3
    } drive_mode_e;

    // B side drives on oe_ab high; A side drives on oe_ba_n low
    function automatic drive_mode_e decode_mode(input logic oe_ab, input logic oe_ba_n);
        unique case ({oe_ab, oe_ba_n})
            2'b01:   return MODE_ISOLATE;
            2'b11:   return MODE_TO_B;
            2'b00:   return MODE_TO_A;
            default: return MODE_BOTH;
        endcase
    endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Unconditional capture: no enable input by design
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    always_comb begin
        y = sel ? stored : live;
    end

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);

    localparam int NDIR  = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    // Per-direction wiring: index 0 carries A toward B, index 1 carries B toward A
    logic [NDIR-1:0] cap_clk;
    logic [NDIR-1:0] path_sel;
    logic [W-1:0]    near_word [NDIR];
    logic [W-1:0]    held_word [NDIR];
    logic [W-1:0]    far_word  [NDIR];

    assign cap_clk[DIR_AB]   = clk_ab;
    assign cap_clk[DIR_BA]   = clk_ba;
    assign path_sel[DIR_AB]  = sel_ab;
    assign path_sel[DIR_BA]  = sel_ba;
    assign near_word[DIR_AB] = a_in;
    assign near_word[DIR_BA] = b_in;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        xcvr_capture_reg #(.W(W)) u_reg (
            .clk (cap_clk[g]),
            .rst (rst),
            .d   (near_word[g]),
            .q   (held_word[g])
        );
        xcvr_path_mux #(.W(W)) u_mux (
            .sel    (path_sel[g]),
            .live   (near_word[g]),
            .stored (held_word[g]),
            .y      (far_word[g])
        );
    end

    assign b_out = far_word[DIR_AB];
    assign a_out = far_word[DIR_BA];

    // Drive-mode decode and output-enable process
    drive_mode_e mode;

    always_comb begin
        mode = decode_mode(oe_ab, oe_ba_n);
    end

    always_comb begin
        unique case (mode)
            MODE_ISOLATE: begin a_oe = '0; b_oe = '0; end
            MODE_TO_B:    begin a_oe = '0; b_oe = '1; end
            MODE_TO_A:    begin a_oe = '1; b_oe = '0; end
            MODE_BOTH:    begin a_oe = '1; b_oe = '1; end
            default:      begin a_oe = '0; b_oe = '0; end
        endcase
    end

    // Enable polarity (R4)
    p_b_enable_r4: assert property (@(posedge clk_ab) disable iff (rst)
        oe_ab |-> (b_oe == '1));
    p_b_quiet_r4: assert property (@(posedge clk_ab) disable iff (rst)
        !oe_ab |-> (b_oe == '0));
    p_a_enable_r4: assert property (@(posedge clk_ba) disable iff (rst)
        !oe_ba_n |-> (a_oe == '1));

    // Isolation drives neither side (R7)
    p_isolate_r7: assert property (@(posedge clk_ab) disable iff (rst)
        (!oe_ab && oe_ba_n) |-> ((a_oe == '0) && (b_oe == '0)));

    // Stored paths show the word seen at the previous capture edge (R2, R3)
    p_store_a_r2: assert property (@(posedge clk_ab) disable iff (rst)
        (sel_ab && !$past(rst)) |-> (b_out == $past(a_in)));
    p_store_b_r3: assert property (@(posedge clk_ba) disable iff (rst)
        (sel_ba && !$past(rst)) |-> (a_out == $past(b_in)));

    // Live paths are transparent (R5, R6)
    p_live_a_r5: assert property (@(posedge clk_ab) disable iff (rst)
        !sel_ab |-> (b_out == a_in));
    p_live_b_r6: assert property (@(posedge clk_ba) disable iff (rst)
        !sel_ba |-> (a_out == b_in));

    // First edge after reset shows a cleared register (R1)
    p_clear_a_r1: assert property (@(posedge clk_ab) disable iff (rst)
        ($past(rst) && sel_ab) |-> (b_out == '0));
    p_clear_b_r1: assert property (@(posedge clk_ba) disable iff (rst)
        ($past(rst) && sel_ba) |-> (a_out == '0));

endmodule

// File: tb/sim_dual_bus_xcvr.sv
module sim_dual_bus_xcvr;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    typedef struct packed {
        logic       oe_ab;
        logic       oe_ba_n;
        logic       sel_ab;
        logic       sel_ba;
        logic       ea_en;
        logic [7:0] ea;
        logic       eb_en;
        logic [7:0] eb;
        logic       pab;
        logic       pba;
        logic [3:0] req;
    } vec_t;

    // oe_ab oe_ba_n sel_ab sel_ba | A drv | B drv | pulses | requirement
    localparam vec_t VECS [9] = '{
        '{1'b0,1'b1,1'b0,1'b0, 1'b1,8'hA1, 1'b1,8'hB1, 1'b1,1'b0, 4'd7},  // R7 isolate, capture A
        '{1'b0,1'b1,1'b1,1'b1, 1'b1,8'hA2, 1'b1,8'hB2, 1'b0,1'b1, 4'd3},  // R3 capture B while isolated
        '{1'b1,1'b1,1'b1,1'b0, 1'b1,8'hA3, 1'b0,8'h00, 1'b0,1'b0, 4'd5},  // R5 stored A onto B
        '{1'b1,1'b1,1'b0,1'b0, 1'b1,8'hA4, 1'b0,8'h00, 1'b0,1'b0, 4'd5},  // R5 live A onto B
        '{1'b0,1'b0,1'b0,1'b1, 1'b0,8'h00, 1'b1,8'hB5, 1'b0,1'b0, 4'd6},  // R6 stored B onto A
        '{1'b0,1'b0,1'b0,1'b0, 1'b0,8'h00, 1'b1,8'hB6, 1'b0,1'b1, 4'd6},  // R6 live B, capture
        '{1'b1,1'b1,1'b1,1'b1, 1'b1,8'hA7, 1'b0,8'h00, 1'b1,1'b0, 4'd2},  // R2 capture while stored shown
        '{1'b0,1'b1,1'b0,1'b1, 1'b1,8'hA8, 1'b1,8'hB8, 1'b1,1'b1, 4'd7},  // R7 both capture isolated
        '{1'b1,1'b0,1'b1,1'b1, 1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0, 4'd10}  // R10 both stored
    };

    logic clk = 1'b0;
    logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic oe_ab = 1'b0, oe_ba_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic ext_a_en = 1'b1, ext_b_en = 1'b1;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] keep_a = '0, keep_b = '0;
    logic [W-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe;
    logic [W-1:0] model_a = '0, model_b = '0;
    int n_chk = 0, n_fail = 0, n_clash = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bus resolution with a registered keeper per bus
    assign a_in = ext_a_en ? ext_a : keep_a;
    assign b_in = ext_b_en ? ext_b : keep_b;
    always @(posedge clk) begin
        keep_a <= a_oe[0] ? a_out : a_in;
        keep_b <= b_oe[0] ? b_out : b_in;
    end
    always @(negedge clk) begin
        if (ext_a_en && a_oe[0] && (ext_a != a_out)) n_clash++;
        if (ext_b_en && b_oe[0] && (ext_b != b_out)) n_clash++;
    end

    dual_bus_xcvr #(.W(W)) u0 (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic pab, input logic pba);
        @(negedge clk);
        if (pab) model_a = rst ? '0 : a_in;
        if (pba) model_b = rst ? '0 : b_in;
        clk_ab = pab;
        clk_ba = pba;
        @(negedge clk);
        clk_ab = 1'b0;
        clk_ba = 1'b0;
    endtask

    task automatic set_ctl(input logic e_ab, input logic e_ba_n, input logic s_ab, input logic s_ba);
        oe_ab = e_ab; oe_ba_n = e_ba_n; sel_ab = s_ab; sel_ba = s_ba;
    endtask

    // Show both registers: both stored, no external drivers
    task automatic show_regs();
        @(negedge clk);
        ext_a_en = 1'b0; ext_b_en = 1'b0;
        set_ctl(1'b1, 1'b0, 1'b1, 1'b1);
        settle();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            report();
            $finish;
        end
    end

    initial begin
        ext_a = 8'h77; ext_b = 8'h99;
        pulse(1'b1, 1'b1);
        pulse(1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        model_a = '0; model_b = '0;

        // R1: reset cleared both registers
        show_regs();
        chk(b_out == 8'h00, "R1 b_out after reset", b_out, 8'h00);
        chk(a_out == 8'h00, "R1 a_out after reset", a_out, 8'h00);

        // Vector table
        foreach (VECS[i]) begin
            @(negedge clk);
            set_ctl(VECS[i].oe_ab, VECS[i].oe_ba_n, VECS[i].sel_ab, VECS[i].sel_ba);
            ext_a_en = VECS[i].ea_en; ext_a = VECS[i].ea;
            ext_b_en = VECS[i].eb_en; ext_b = VECS[i].eb;
            settle();
            if (VECS[i].pab || VECS[i].pba) pulse(VECS[i].pab, VECS[i].pba);
            settle();
            chk(b_oe == {W{VECS[i].oe_ab}}, $sformatf("R4 b_oe vec%0d (R%0d)", i, VECS[i].req),
                b_oe, {W{VECS[i].oe_ab}});
            chk(a_oe == {W{!VECS[i].oe_ba_n}}, $sformatf("R4 a_oe vec%0d (R%0d)", i, VECS[i].req),
                a_oe, {W{!VECS[i].oe_ba_n}});
            chk(b_out == (VECS[i].sel_ab ? model_a : a_in), $sformatf("R5 b_out vec%0d (R%0d)", i, VECS[i].req),
                b_out, VECS[i].sel_ab ? model_a : a_in);
            chk(a_out == (VECS[i].sel_ba ? model_b : b_in), $sformatf("R6 a_out vec%0d (R%0d)", i, VECS[i].req),
                a_out, VECS[i].sel_ba ? model_b : b_in);
        end

        // R10 with known register contents from the table: A8 and B8
        chk(b_out == 8'hA8, "R10 stored A on B", b_out, 8'hA8);
        chk(a_out == 8'hB8, "R10 stored B on A", a_out, 8'hB8);

        // R8: B driven from A, both clocks copy the A word
        @(negedge clk);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        ext_a_en = 1'b1; ext_a = 8'h3C; ext_b_en = 1'b0;
        settle();
        pulse(1'b1, 1'b1);
        show_regs();
        chk(b_out == 8'h3C, "R8 A register", b_out, 8'h3C);
        chk(a_out == 8'h3C, "R8 B register", a_out, 8'h3C);

        // R9: A driven from B, both clocks copy the B word
        @(negedge clk);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
        ext_b_en = 1'b1; ext_b = 8'hC3; ext_a_en = 1'b0;
        settle();
        pulse(1'b1, 1'b1);
        show_regs();
        chk(b_out == 8'hC3, "R9 A register", b_out, 8'hC3);
        chk(a_out == 8'hC3, "R9 B register", a_out, 8'hC3);

        // R11: establish 5A on both buses, then close the live loop
        @(negedge clk);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0);
        ext_a_en = 1'b1; ext_a = 8'h5A; ext_b_en = 1'b0;
        settle();
        @(negedge clk);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        ext_a_en = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(a_out == 8'h5A, "R11 A bus held", a_out, 8'h5A);
        chk(b_out == 8'h5A, "R11 B bus held", b_out, 8'h5A);
        chk(a_in == 8'h5A, "R11 A bus resolved", a_in, 8'h5A);

        // R1 again: reset mid-run clears only the pulsed register
        @(negedge clk);
        rst = 1'b1;
        pulse(1'b1, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        show_regs();
        chk(b_out == 8'h00, "R1 A register cleared", b_out, 8'h00);
        chk(a_out == 8'hC3, "R1 B register untouched", a_out, 8'hC3);

        chk(n_clash == 0, "R4 no bus contention", 8'(n_clash), 8'h00);

        done = 1'b1;
        report();
        $finish;
    end

endmodule